// File: doc/BRIEF.md
# Grouped Interrupt Vector Controller

This block gathers a wide bank of edge-signalled interrupt vectors, 32 per group with up to eight groups, and reduces each group to one interrupt line toward an upstream controller. Every vector has its own pending bit, which is captured on a rising edge of the vector and held until software acknowledges it. Every vector also has its own enable bit that gates whether its pending bit can raise the group's line.

Software reaches the state through a 32-bit register port with word addressing. Each group has a pending (cause) word at byte offset 4*g and an enable word at byte offset 0x20 + 4*g. An interrupt handler reads the cause words to find which vectors are pending. It writes ones back to acknowledge them. It can read the enable words back so that it can save and later restore the mask state.

Top module: `vecgrp_irq_ctrl`

## Requirements
- R1: Vector n maps to group n/32 at bit n mod 32, and the pending word of group g reads at byte offset 4*g (g = 0..7).
- R2: A 0-to-1 transition on a vector input sets its pending bit whether or not the vector is enabled; a vector held high sets it only once.
- R3: A pending bit stays set until a register write to its pending word carries a 1 in that bit position; bits written as 0 are left unchanged.
- R4: When a rising edge and an acknowledge of the same bit land in the same clock cycle, the bit ends up set, while other acknowledged bits of that write are cleared.
- R5: The enable word of group g sits at byte offset 0x20 + 4*g, takes the written value whole, and reads back that value; a 1 unmasks a vector.
- R6: Output parent_irq[g] is high exactly when (pending word g AND enable word g) was non-zero at the previous clock edge, so it follows the condition with one cycle of delay.
- R7: After reset every pending bit, every enable bit, every parent_irq output and read data are 0.
- R8: A read of any byte offset other than the 16 word-aligned offsets 0x00..0x3C returns 0, and a write to such an offset changes no state.
- R9: Read data appears on cfg_rdata on the clock edge that samples cfg_rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_in | input | 256 | Vector inputs; bit n is vector n |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Byte offset of the accessed register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| parent_irq | output | 8 | One interrupt line per group |

## Verification
A new edge on a vector and a software acknowledge of the same pending word can fall in the same cycle. The bench drives a rising edge on one vector at the same edge as a pending-word write that has ones both in that vector's bit and in a second bit that was already pending. It then reads the word back and expects the first bit set and the second bit cleared. A related collision is an enable write and a pending change in one cycle; here the bench judges the group line one cycle later against the requirement.

// File: rtl/vecgrp_pkg.sv
package vecgrp_pkg;

    localparam int unsigned WORD_W       = 32;
    localparam int unsigned MAX_GROUPS   = 8;
    localparam int unsigned EN_WORD_BASE = MAX_GROUPS;
    localparam int unsigned MAPPED_WORDS = 2 * MAX_GROUPS;

    typedef struct packed {
        logic [WORD_W-1:0] cause;
        logic [WORD_W-1:0] en;
        logic              irq;
    } grp_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_state_t;

endpackage

// File: rtl/vecgrp_edge_detect.sv
module vecgrp_edge_detect #(
    parameter int unsigned WIDTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_in,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_in;
        rise   = sig_in & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // A level held high gives one rise only
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & $past(sig_in)) == '0));

endmodule

// File: rtl/vecgrp_group.sv
module vecgrp_group
    import vecgrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rise,
    input  logic              wr_cause,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cause,
    output logic [WORD_W-1:0] enable,
    output logic              irq
);

    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cause) st_d.cause = st_q.cause & ~wdata;
        st_d.cause = st_d.cause | rise;
        if (wr_en) st_d.en = wdata;
        st_d.irq = |(st_q.cause & st_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause  = st_q.cause;
    assign enable = st_q.en;
    assign irq    = st_q.irq;

    assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((cause & $past(rise)) == $past(rise)));

    assert_clear_on_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cause |=> ((cause & $past(wdata & ~rise)) == '0));

    assert_hold_without_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cause |=> (($past(cause) & ~cause) == '0));

    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cause && ((wdata & rise) != '0)) |=> ((cause & $past(wdata & rise)) == $past(wdata & rise)));

    assert_enable_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (enable == $past(wdata)));

    assert_enable_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enable));

    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & enable) != '0) |=> irq);

    assert_irq_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & enable) == '0) |=> !irq);

endmodule

// File: rtl/vecgrp_regif.sv
module vecgrp_regif
    import vecgrp_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned ADDR_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic                         rd,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NUM_GROUPS*WORD_W-1:0] cause_flat,
    input  logic [NUM_GROUPS*WORD_W-1:0] en_flat,
    output logic [NUM_GROUPS-1:0]        wr_cause,
    output logic [NUM_GROUPS-1:0]        wr_en,
    output logic [WORD_W-1:0]            rdata
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    rd_state_t         rs_d, rs_q;
    logic [IDX_W-1:0]  idx;
    logic              aligned;
    logic [WORD_W-1:0] rd_word;

    always_comb begin
        idx      = addr[ADDR_W-1:2];
        aligned  = (addr[1:0] == 2'b00);
        wr_cause = '0;
        wr_en    = '0;
        rd_word  = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (aligned && idx == IDX_W'(g)) begin
                wr_cause[g] = wr;
                rd_word     = cause_flat[g*WORD_W +: WORD_W];
            end
            if (aligned && idx == IDX_W'(EN_WORD_BASE + g)) begin
                wr_en[g] = wr;
                rd_word  = en_flat[g*WORD_W +: WORD_W];
            end
        end
        rs_d = rs_q;
        if (rd) rs_d.rdata = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rdata = rs_q.rdata;

    assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (addr[1:0] != 2'b00 || addr[ADDR_W-1:2] >= IDX_W'(MAPPED_WORDS))) |=> (rdata == '0));

    assert_unmapped_write_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr[1:0] != 2'b00) |-> (wr_cause == '0 && wr_en == '0));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/vecgrp_irq_ctrl.sv
module vecgrp_irq_ctrl
    import vecgrp_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned ADDR_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_GROUPS*WORD_W-1:0] vec_in,
    input  logic                         cfg_wr_en,
    input  logic                         cfg_rd_en,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [WORD_W-1:0]            cfg_wdata,
    output logic [WORD_W-1:0]            cfg_rdata,
    output logic [NUM_GROUPS-1:0]        parent_irq
);

    localparam int unsigned NUM_VEC = NUM_GROUPS * WORD_W;

    logic [NUM_VEC-1:0]    rise;
    logic [NUM_VEC-1:0]    cause_flat;
    logic [NUM_VEC-1:0]    en_flat;
    logic [NUM_GROUPS-1:0] wr_cause;
    logic [NUM_GROUPS-1:0] wr_en;

    vecgrp_edge_detect #(.WIDTH(NUM_VEC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (vec_in),
        .rise   (rise)
    );

    vecgrp_regif #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_wr_en),
        .rd         (cfg_rd_en),
        .addr       (cfg_addr),
        .cause_flat (cause_flat),
        .en_flat    (en_flat),
        .wr_cause   (wr_cause),
        .wr_en      (wr_en),
        .rdata      (cfg_rdata)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        vecgrp_group u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise     (rise[g*WORD_W +: WORD_W]),
            .wr_cause (wr_cause[g]),
            .wr_en    (wr_en[g]),
            .wdata    (cfg_wdata),
            .cause    (cause_flat[g*WORD_W +: WORD_W]),
            .enable   (en_flat[g*WORD_W +: WORD_W]),
            .irq      (parent_irq[g])
        );
    end

    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |=> (parent_irq == '0 && cfg_rdata == '0));

endmodule

// File: tb/vecgrp_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vecgrp_irq_ctrl_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] vec_in = '0;
    logic         cfg_wr_en = 1'b0;
    logic         cfg_rd_en = 1'b0;
    logic [7:0]   cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic [31:0]  cfg_rdata;
    logic [7:0]   parent_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vecgrp_irq_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .vec_in     (vec_in),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_rd_en  (cfg_rd_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .parent_irq (parent_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_addr = a;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R7 irq after reset", {24'b0, parent_irq}, 32'h0);
        chk("R7 rdata after reset", cfg_rdata, 32'h0);
        for (int w = 0; w < 16; w++) begin
            reg_read(8'(4*w), d);
            chk("R7 word after reset", d, 32'h0);
        end
    endtask

    task automatic t_mapping;
        logic [31:0] d;
        @(negedge clk); vec_in[75] = 1'b1;    // group 2, bit 11
        reg_read(8'h08, d);
        chk("R1 vector 75 in word 2 bit 11", d, 32'h0000_0800);
        reg_read(8'h04, d);
        chk("R1 word 1 untouched", d, 32'h0);
        chk("R2 masked vector keeps line low", {24'b0, parent_irq}, 32'h0);
        reg_read(8'h1C, d);
        chk("R9 read data holds across idle", cfg_rdata, 32'h0);
        vec_in[255] = 1'b1;                   // group 7, bit 31
        reg_read(8'h1C, d);
        chk("R1 vector 255 in word 7 bit 31", d, 32'h8000_0000);
    endtask

    task automatic t_ack;
        logic [31:0] d;
        reg_write(8'h08, 32'h0);
        reg_read(8'h08, d);
        chk("R3 zero write keeps pending", d, 32'h0000_0800);
        reg_write(8'h08, 32'h0000_0800);
        repeat (3) @(negedge clk);
        reg_read(8'h08, d);
        chk("R2 held level does not re-set", d, 32'h0);
        reg_write(8'h1C, 32'hFFFF_FFFF);
        reg_read(8'h1C, d);
        chk("R3 all-ones write clears group", d, 32'h0);
    endtask

    task automatic t_enable_irq;
        logic [31:0] d;
        reg_write(8'h28, 32'h0000_0800);
        reg_read(8'h28, d);
        chk("R5 enable word 2 readback", d, 32'h0000_0800);
        @(negedge clk); vec_in[75] = 1'b0;
        @(negedge clk); vec_in[75] = 1'b1;
        @(negedge clk);
        chk("R6 line low in cycle pending sets", {31'b0, parent_irq[2]}, 32'h0);
        @(negedge clk);
        chk("R6 line high one cycle later", {24'b0, parent_irq}, 32'h0000_0004);
        reg_write(8'h08, 32'h0000_0800);
        chk("R6 line still high right after ack", {31'b0, parent_irq[2]}, 32'h1);
        @(negedge clk);
        chk("R6 line low one cycle after ack", {24'b0, parent_irq}, 32'h0);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        @(negedge clk); vec_in[201] = 1'b1;   // group 6, bit 9
        @(negedge clk);
        // rise on bit 8 and ack of bits 8 and 9 in the same cycle
        vec_in[200] = 1'b1;
        cfg_wr_en = 1'b1; cfg_addr = 8'h18; cfg_wdata = 32'h0000_0300;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        reg_read(8'h18, d);
        chk("R4 set wins, other ack clears", d, 32'h0000_0100);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        reg_write(8'h40, 32'hFFFF_FFFF);
        reg_write(8'h29, 32'hFFFF_FFFF);
        reg_write(8'hFC, 32'h0);
        reg_read(8'h40, d);
        chk("R8 read of 0x40 is zero", d, 32'h0);
        reg_read(8'h19, d);
        chk("R8 unaligned read is zero", d, 32'h0);
        reg_read(8'h28, d);
        chk("R8 enable 2 unchanged by stray writes", d, 32'h0000_0800);
        reg_read(8'h18, d);
        chk("R8 cause 6 unchanged by stray writes", d, 32'h0000_0100);
        for (int w = 8; w < 16; w++) begin
            if (w != 10) begin
                reg_read(8'(4*w), d);
                chk("R8 other enable words stay zero", d, 32'h0);
            end
        end
    endtask

    task automatic t_all_groups;
        logic [31:0] d;
        @(negedge clk); vec_in = '0;
        for (int g = 0; g < 8; g++) reg_write(8'(4*g), 32'hFFFF_FFFF);
        for (int g = 0; g < 8; g++) reg_write(8'(8'h20 + 4*g), 32'hFFFF_FFFF);
        @(negedge clk);
        for (int g = 0; g < 8; g++) vec_in[g*32 + g] = 1'b1;
        @(negedge clk);
        for (int g = 0; g < 8; g++) begin
            reg_read(8'(4*g), d);
            chk("R1 diagonal vector per group", d, 32'(1) << g);
        end
        chk("R6 every group line high", {24'b0, parent_irq}, 32'h0000_00FF);
        for (int g = 0; g < 8; g++) reg_write(8'(8'h20 + 4*g), 32'h0);
        @(negedge clk);
        chk("R5 zero enable masks every group", {24'b0, parent_irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mapping();
        t_ack();
        t_enable_irq();
        t_collision();
        t_unmapped();
        t_all_groups();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule